// File: doc/BRIEF.md
# PLL Bring-Up and Idle Sequencer

This block takes over the bring-up and shut-down of a PHY reference PLL. It acts as a master on a small register port that reaches the PLL control registers. An init request first takes the PLL out of idle if needed and waits for lock. If the PLL is still unlocked, the block looks up the divider settings for the selected reference rate in a table for the chosen mode. It merges each field into its configuration word with a read-modify-write, writes the start command and waits for lock. An exit request puts the PLL into idle and waits until both the regulator and the oscillator report that they are powered down.

The reference rate is chosen with a 3-bit index and a valid flag. The mode input selects one of two divider tables, a USB-style table or a SATA-style table. In SATA-style mode, exit is refused and completes at once. The block pulses done on success, or pulses err with a reason code. Both timeouts are a parameterised number of milliseconds, converted to cycles from the clock frequency.

Top module: `pll_bringup_seq`

## Requirements
- R1: After reset, bus_req, busy, done and err are low and err_code is 0.
- R2: A transfer completes in a cycle where bus_req and bus_ack are both high. While bus_req is high and bus_ack is low, bus_req stays high and bus_addr, bus_we and bus_wdata hold their values. Only one transfer is outstanding at a time.
- R3: On init, the block reads word 0x10. If bit 0 (idle) is set, it writes the word back with bit 0 cleared and all other bits kept, then polls word 0x04 until bit 1 (lock) is set.
- R4: If status word 0x04 has bit 1 set when it is checked during init, the block writes no configuration word and reports done.
- R5: When unlocked, it programs five fields with read-modify-write, preserving all other bits, in this fixed order: N into 0x0C[8:1], frequency select into 0x10[3:1], M into 0x0C[20:9], fractional M into 0x20[17:0], SD into 0x14[17:10].
- R6: After the five fields, it writes value 1 to word 0x08, then polls 0x04 bit 1 and reports done once it is set.
- R7: If lock is not seen within the timeout (no earlier than TIMEOUT_MS milliseconds of clock), the block pulses err with err_code 1.
- R8: With rate_vld low or rate_idx above 5, an init that finds the PLL unlocked pulses err with err_code 2 and writes no register.
- R9: On exit in USB-style mode (sata_mode low), the block sets bit 0 of word 0x10, keeping the other bits, then polls 0x04 until bits 15 and 16 are both set, and reports done.
- R10: If either power-down flag is still low at the timeout, exit pulses err with err_code 1.
- R11: In SATA-style mode (sata_mode high), exit reports done without any bus transfer.
- R12: Rate index 0..5 selects 12, 16.8, 19.2, 20, 26 and 38.4 MHz. In USB-style mode, index 2 gives M=1172, N=8, freq=4, SD=20, MF=65537. In SATA-style mode every index uses N=7, freq=4, SD=6, MF=0, and M runs 1000, 714, 625, 600, 461, 312.
- R13: done and err are one-cycle pulses and are never high together. Requests that arrive while busy is high are ignored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| init_req | input | 1 | Start bring-up (taken when idle) |
| exit_req | input | 1 | Start shut-down (taken when idle; init wins if both are high) |
| sata_mode | input | 1 | 1 selects the SATA-style table and exit refusal |
| rate_idx | input | 3 | Reference-rate index |
| rate_vld | input | 1 | Rate index is meaningful |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | Success pulse |
| err | output | 1 | Failure pulse |
| err_code | output | 2 | Failure reason: 1 timeout, 2 unsupported rate |
| bus_req | output | 1 | Transfer request |
| bus_we | output | 1 | 1 write, 0 read |
| bus_addr | output | 8 | Register byte offset |
| bus_wdata | output | 32 | Write data |
| bus_ack | input | 1 | Transfer completion |
| bus_rdata | input | 32 | Read data, valid with bus_ack |

## Verification
The bench presets configuration words with unrelated bits set and checks their final values. A design that applied a field with a plain write, or used the wrong bit position, would wipe or corrupt those bits. It records every write address to catch a wrong programming order, and checks that a PLL found locked or an unsupported rate leads to no writes at all. Both timeout paths are run to their end to show the error code and that the wait does not expire early. SATA-style exit must make no bus access, and a request made while busy must cause neither a second sequence nor a second pulse.

// File: rtl/pll_bringup_pkg.sv
package pll_bringup_pkg;

    localparam int DATA_W    = 32;
    localparam int ADDR_W    = 8;
    localparam int IDX_W     = 3;
    localparam int NUM_RATES = 6;
    localparam int NUM_STEPS = 5;
    localparam int STEP_W    = $clog2(NUM_STEPS);

    localparam logic [ADDR_W-1:0] A_STAT = 8'h04;
    localparam logic [ADDR_W-1:0] A_GO   = 8'h08;
    localparam logic [ADDR_W-1:0] A_CFG1 = 8'h0C;
    localparam logic [ADDR_W-1:0] A_CFG2 = 8'h10;
    localparam logic [ADDR_W-1:0] A_CFG3 = 8'h14;
    localparam logic [ADDR_W-1:0] A_CFG4 = 8'h20;

    localparam int B_LOCK    = 1;
    localparam int B_LDO_OFF = 15;
    localparam int B_OSC_OFF = 16;
    localparam int B_IDLE    = 0;

    typedef struct packed {
        logic [11:0] m;
        logic [7:0]  n;
        logic [2:0]  freq;
        logic [7:0]  sd;
        logic [17:0] mf;
    } div_t;

    typedef enum logic [1:0] {
        ERR_NONE    = 2'd0,
        ERR_TIMEOUT = 2'd1,
        ERR_BADRATE = 2'd2
    } err_e;

    typedef enum logic [3:0] {
        S_IDLE, S_RD_CFG2, S_CLR_IDLE, S_WAIT_UNIDLE, S_RD_STAT,
        S_RMW_RD, S_RMW_WR, S_GO, S_WAIT_LOCK, S_EX_RD, S_EX_WR, S_WAIT_PD
    } st_e;

    function automatic logic [ADDR_W-1:0] step_addr(input logic [STEP_W-1:0] s);
        case (s)
            3'd0:    return A_CFG1;
            3'd1:    return A_CFG2;
            3'd2:    return A_CFG1;
            3'd3:    return A_CFG4;
            default: return A_CFG3;
        endcase
    endfunction

    function automatic int step_lsb(input logic [STEP_W-1:0] s);
        case (s)
            3'd0:    return 1;
            3'd1:    return 1;
            3'd2:    return 9;
            3'd3:    return 0;
            default: return 10;
        endcase
    endfunction

    function automatic int step_width(input logic [STEP_W-1:0] s);
        case (s)
            3'd0:    return 8;
            3'd1:    return 3;
            3'd2:    return 12;
            3'd3:    return 18;
            default: return 8;
        endcase
    endfunction

    function automatic logic [DATA_W-1:0] step_val(input logic [STEP_W-1:0] s, input div_t d);
        case (s)
            3'd0:    return DATA_W'(d.n);
            3'd1:    return DATA_W'(d.freq);
            3'd2:    return DATA_W'(d.m);
            3'd3:    return DATA_W'(d.mf);
            default: return DATA_W'(d.sd);
        endcase
    endfunction

    function automatic logic [DATA_W-1:0] merge_field(input logic [DATA_W-1:0] old,
                                                      input logic [STEP_W-1:0] s,
                                                      input div_t d);
        logic [DATA_W-1:0] mask;
        mask = ((DATA_W'(1) << step_width(s)) - DATA_W'(1)) << step_lsb(s);
        return (old & ~mask) | ((step_val(s, d) << step_lsb(s)) & mask);
    endfunction

endpackage

// File: rtl/pll_bringup_rates.sv
module pll_bringup_rates
    import pll_bringup_pkg::*;
(
    input  logic             sata,
    input  logic [IDX_W-1:0] idx,
    input  logic             vld,
    output div_t             div,
    output logic             ok
);

    localparam int MAX_IDX = NUM_RATES - 1;

    div_t usb_d;
    div_t sata_d;

    assign ok = vld && (int'(idx) <= MAX_IDX);

    always_comb begin
        usb_d = '{m: 12'd1250, n: 8'd5, freq: 3'd4, sd: 8'd20, mf: 18'd0};
        case (idx)
            3'd0: usb_d = '{m: 12'd1250, n: 8'd5,  freq: 3'd4, sd: 8'd20, mf: 18'd0};
            3'd1: usb_d = '{m: 12'd3125, n: 8'd20, freq: 3'd4, sd: 8'd20, mf: 18'd0};
            3'd2: usb_d = '{m: 12'd1172, n: 8'd8,  freq: 3'd4, sd: 8'd20, mf: 18'd65537};
            3'd3: usb_d = '{m: 12'd1000, n: 8'd7,  freq: 3'd4, sd: 8'd10, mf: 18'd0};
            3'd4: usb_d = '{m: 12'd1250, n: 8'd12, freq: 3'd4, sd: 8'd20, mf: 18'd0};
            3'd5: usb_d = '{m: 12'd3125, n: 8'd47, freq: 3'd4, sd: 8'd20, mf: 18'd92843};
            default: ;
        endcase
    end

    always_comb begin
        sata_d = '{m: 12'd1000, n: 8'd7, freq: 3'd4, sd: 8'd6, mf: 18'd0};
        case (idx)
            3'd1: sata_d.m = 12'd714;
            3'd2: sata_d.m = 12'd625;
            3'd3: sata_d.m = 12'd600;
            3'd4: sata_d.m = 12'd461;
            3'd5: sata_d.m = 12'd312;
            default: ;
        endcase
    end

    assign div = sata ? sata_d : usb_d;

endmodule

// File: rtl/pll_bringup_timer.sv
module pll_bringup_timer #(
    parameter int unsigned LIMIT = 1000
) (
    input  logic clk,
    input  logic rst,
    input  logic run,
    output logic expired
);

    localparam int CNT_W = $clog2(LIMIT + 1);
    localparam logic [CNT_W-1:0] LIM = CNT_W'(LIMIT);

    logic [CNT_W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst || !run) cnt <= '0;
        else if (cnt != LIM) cnt <= cnt + 1'b1;
    end

    assign expired = (cnt == LIM);

    // R7: the timeout can only be reached after the wait has been running
    a_r7_expiry_needs_run: assert property (@(posedge clk) disable iff (rst)
        $rose(expired) |-> $past(run));

endmodule

// File: rtl/pll_bringup_fsm.sv
module pll_bringup_fsm
    import pll_bringup_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              init_req,
    input  logic              exit_req,
    input  logic              sata_mode,
    input  logic [IDX_W-1:0]  rate_idx,
    input  logic              rate_vld,
    output logic              sel_sata,
    output logic [IDX_W-1:0]  sel_idx,
    output logic              sel_vld,
    input  div_t              div,
    input  logic              rate_ok,
    output logic              tmr_run,
    input  logic              tmr_expired,
    output logic              busy,
    output logic              done,
    output logic              err,
    output logic [1:0]        err_code,
    output logic              bus_req,
    output logic              bus_we,
    output logic [ADDR_W-1:0] bus_addr,
    output logic [DATA_W-1:0] bus_wdata,
    input  logic              bus_ack,
    input  logic [DATA_W-1:0] bus_rdata
);

    st_e               st;
    logic [DATA_W-1:0] rd_q;
    logic [STEP_W-1:0] step;
    logic              late_q;
    logic              done_q, err_q;
    err_e              code_q;

    assign sel_sata = sel_sata_q;
    assign sel_idx  = idx_q;
    assign sel_vld  = vld_q;
    logic              sel_sata_q;
    logic [IDX_W-1:0]  idx_q;
    logic              vld_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            st         <= S_IDLE;
            rd_q       <= '0;
            step       <= '0;
            late_q     <= 1'b0;
            sel_sata_q <= 1'b0;
            idx_q      <= '0;
            vld_q      <= 1'b0;
            done_q     <= 1'b0;
            err_q      <= 1'b0;
            code_q     <= ERR_NONE;
        end else begin
            done_q <= 1'b0;
            err_q  <= 1'b0;
            if (bus_ack && !bus_we) rd_q <= bus_rdata;
            case (st)
                S_IDLE: begin
                    if (init_req) begin
                        sel_sata_q <= sata_mode;
                        idx_q      <= rate_idx;
                        vld_q      <= rate_vld;
                        late_q     <= 1'b0;
                        st         <= S_RD_CFG2;
                    end else if (exit_req) begin
                        sel_sata_q <= sata_mode;
                        if (sata_mode) begin
                            done_q <= 1'b1;
                            code_q <= ERR_NONE;
                        end else begin
                            st <= S_EX_RD;
                        end
                    end
                end
                S_RD_CFG2: if (bus_ack)
                    st <= bus_rdata[B_IDLE] ? S_CLR_IDLE : S_RD_STAT;
                S_CLR_IDLE: if (bus_ack) st <= S_WAIT_UNIDLE;
                S_WAIT_UNIDLE: if (bus_ack) begin
                    if (bus_rdata[B_LOCK]) st <= S_RD_STAT;
                    else if (tmr_expired) begin
                        late_q <= 1'b1;
                        st     <= S_RD_STAT;
                    end
                end
                S_RD_STAT: if (bus_ack) begin
                    if (bus_rdata[B_LOCK]) begin
                        st     <= S_IDLE;
                        done_q <= !late_q;
                        err_q  <= late_q;
                        code_q <= late_q ? ERR_TIMEOUT : ERR_NONE;
                    end else if (!rate_ok) begin
                        st     <= S_IDLE;
                        err_q  <= 1'b1;
                        code_q <= ERR_BADRATE;
                    end else begin
                        step <= '0;
                        st   <= S_RMW_RD;
                    end
                end
                S_RMW_RD: if (bus_ack) st <= S_RMW_WR;
                S_RMW_WR: if (bus_ack) begin
                    if (int'(step) == NUM_STEPS - 1) st <= S_GO;
                    else begin
                        step <= step + 1'b1;
                        st   <= S_RMW_RD;
                    end
                end
                S_GO: if (bus_ack) st <= S_WAIT_LOCK;
                S_WAIT_LOCK: if (bus_ack) begin
                    if (bus_rdata[B_LOCK] || tmr_expired) begin
                        st <= S_IDLE;
                        if (bus_rdata[B_LOCK] && !late_q) begin
                            done_q <= 1'b1;
                            code_q <= ERR_NONE;
                        end else begin
                            err_q  <= 1'b1;
                            code_q <= ERR_TIMEOUT;
                        end
                    end
                end
                S_EX_RD: if (bus_ack) st <= S_EX_WR;
                S_EX_WR: if (bus_ack) st <= S_WAIT_PD;
                S_WAIT_PD: if (bus_ack) begin
                    if (bus_rdata[B_LDO_OFF] && bus_rdata[B_OSC_OFF]) begin
                        st     <= S_IDLE;
                        done_q <= 1'b1;
                        code_q <= ERR_NONE;
                    end else if (tmr_expired) begin
                        st     <= S_IDLE;
                        err_q  <= 1'b1;
                        code_q <= ERR_TIMEOUT;
                    end
                end
                default: st <= S_IDLE;
            endcase
        end
    end

    always_comb begin
        bus_req   = (st != S_IDLE);
        bus_we    = 1'b0;
        bus_addr  = A_STAT;
        bus_wdata = '0;
        case (st)
            S_RD_CFG2, S_EX_RD: bus_addr = A_CFG2;
            S_CLR_IDLE: begin
                bus_we    = 1'b1;
                bus_addr  = A_CFG2;
                bus_wdata = rd_q & ~(DATA_W'(1) << B_IDLE);
            end
            S_EX_WR: begin
                bus_we    = 1'b1;
                bus_addr  = A_CFG2;
                bus_wdata = rd_q | (DATA_W'(1) << B_IDLE);
            end
            S_RMW_RD: bus_addr = step_addr(step);
            S_RMW_WR: begin
                bus_we    = 1'b1;
                bus_addr  = step_addr(step);
                bus_wdata = merge_field(rd_q, step, div);
            end
            S_GO: begin
                bus_we    = 1'b1;
                bus_addr  = A_GO;
                bus_wdata = DATA_W'(1);
            end
            default: ;
        endcase
    end

    assign tmr_run  = (st == S_WAIT_UNIDLE) || (st == S_WAIT_LOCK) || (st == S_WAIT_PD);
    assign busy     = (st != S_IDLE);
    assign done     = done_q;
    assign err      = err_q;
    assign err_code = code_q;

    // R2: a pending request holds its address, direction and data until acknowledged
    a_r2_req_held: assert property (@(posedge clk) disable iff (rst)
        (bus_req && !bus_ack) |=> (bus_req && $stable(bus_addr) && $stable(bus_we) && $stable(bus_wdata)));

    // R6: the only value ever written to the start register is 1
    a_r6_go_value: assert property (@(posedge clk) disable iff (rst)
        (bus_req && bus_we && bus_addr == A_GO) |-> (bus_wdata == DATA_W'(1)));

    // R8: configuration other than the idle word is written only with a supported rate
    a_r8_no_write_bad_rate: assert property (@(posedge clk) disable iff (rst)
        (bus_req && bus_we && bus_addr != A_CFG2) |-> rate_ok);

    // R13: single-cycle, mutually exclusive completion pulses
    a_r13_done_pulse: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);
    a_r13_err_pulse: assert property (@(posedge clk) disable iff (rst)
        err |=> !err);
    a_r13_exclusive: assert property (@(posedge clk) disable iff (rst)
        !(done && err));

    // R11: SATA-style exit finishes without leaving idle
    a_r11_sata_exit: assert property (@(posedge clk) disable iff (rst)
        (!busy && !init_req && exit_req && sata_mode) |=> (done && !bus_req));

endmodule

// File: rtl/pll_bringup_seq.sv
module pll_bringup_seq
    import pll_bringup_pkg::*;
#(
    parameter int unsigned CLK_FREQ_HZ = 100_000_000,
    parameter int unsigned TIMEOUT_MS  = 100
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        init_req,
    input  logic        exit_req,
    input  logic        sata_mode,
    input  logic [2:0]  rate_idx,
    input  logic        rate_vld,
    output logic        busy,
    output logic        done,
    output logic        err,
    output logic [1:0]  err_code,
    output logic        bus_req,
    output logic        bus_we,
    output logic [7:0]  bus_addr,
    output logic [31:0] bus_wdata,
    input  logic        bus_ack,
    input  logic [31:0] bus_rdata
);

    localparam int unsigned TIMEOUT_CYC = (CLK_FREQ_HZ / 1000) * TIMEOUT_MS;

    logic             sel_sata, sel_vld, rate_ok, tmr_run, tmr_expired;
    logic [IDX_W-1:0] sel_idx;
    div_t             div;

    pll_bringup_rates u_rates (
        .sata (sel_sata),
        .idx  (sel_idx),
        .vld  (sel_vld),
        .div  (div),
        .ok   (rate_ok)
    );

    pll_bringup_timer #(.LIMIT(TIMEOUT_CYC)) u_timer (
        .clk     (clk),
        .rst     (rst),
        .run     (tmr_run),
        .expired (tmr_expired)
    );

    pll_bringup_fsm u_fsm (
        .clk         (clk),
        .rst         (rst),
        .init_req    (init_req),
        .exit_req    (exit_req),
        .sata_mode   (sata_mode),
        .rate_idx    (rate_idx),
        .rate_vld    (rate_vld),
        .sel_sata    (sel_sata),
        .sel_idx     (sel_idx),
        .sel_vld     (sel_vld),
        .div         (div),
        .rate_ok     (rate_ok),
        .tmr_run     (tmr_run),
        .tmr_expired (tmr_expired),
        .busy        (busy),
        .done        (done),
        .err         (err),
        .err_code    (err_code),
        .bus_req     (bus_req),
        .bus_we      (bus_we),
        .bus_addr    (bus_addr),
        .bus_wdata   (bus_wdata),
        .bus_ack     (bus_ack),
        .bus_rdata   (bus_rdata)
    );

endmodule

// File: tb/pll_bringup_seq_tb.sv
module pll_bringup_seq_tb;

    localparam int unsigned TB_HZ  = 50_000;
    localparam int unsigned TB_MS  = 100;
    localparam int          TO_CYC = (TB_HZ / 1000) * TB_MS;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        init_req = 1'b0, exit_req = 1'b0, sata_mode = 1'b0, rate_vld = 1'b0;
    logic [2:0]  rate_idx = 3'd0;
    logic        busy, done, err, bus_req, bus_we;
    logic [1:0]  err_code;
    logic [7:0]  bus_addr;
    logic [31:0] bus_wdata;
    logic        s_ack = 1'b0;
    logic [31:0] s_rdata = 32'h0;

    always #10 clk = ~clk;

    pll_bringup_seq #(.CLK_FREQ_HZ(TB_HZ), .TIMEOUT_MS(TB_MS)) u_dut (
        .clk(clk), .rst(rst), .init_req(init_req), .exit_req(exit_req),
        .sata_mode(sata_mode), .rate_idx(rate_idx), .rate_vld(rate_vld),
        .busy(busy), .done(done), .err(err), .err_code(err_code),
        .bus_req(bus_req), .bus_we(bus_we), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_ack(s_ack), .bus_rdata(s_rdata)
    );

    int n_chk = 0;
    int n_bad = 0;

    // register model
    logic [31:0] regs [0:15];
    logic [7:0]  wr_addr [0:15];
    logic [31:0] wr_data [0:15];
    int          wr_n = 0;
    int          acc_n = 0;
    int          pend_cnt = 0;
    int          pend_kind = 0;
    logic        load_req = 1'b0;
    logic [31:0] pre_cfg1, pre_cfg2, pre_cfg3, pre_cfg4, pre_stat;
    logic        lock_ok = 1'b0, pd_ok = 1'b0;
    int          stab_bad = 0;
    logic        prev_pend = 1'b0;
    logic [7:0]  prev_addr;
    logic [31:0] prev_wdata;
    logic        prev_we;

    always @(posedge clk) begin
        if (load_req) begin
            for (int i = 0; i < 16; i++) regs[i] <= 32'h0;
            regs[1] <= pre_stat;
            regs[3] <= pre_cfg1;
            regs[4] <= pre_cfg2;
            regs[5] <= pre_cfg3;
            regs[8] <= pre_cfg4;
            wr_n <= 0;
            acc_n <= 0;
            pend_cnt <= 0;
            s_ack <= 1'b0;
        end else begin
            if (bus_req && !s_ack) begin
                s_ack <= 1'b1;
                acc_n <= acc_n + 1;
                if (bus_we) begin
                    regs[bus_addr[5:2]] <= bus_wdata;
                    if (wr_n < 16) begin
                        wr_addr[wr_n] <= bus_addr;
                        wr_data[wr_n] <= bus_wdata;
                    end
                    wr_n <= wr_n + 1;
                    if (bus_addr == 8'h08 && bus_wdata[0] && lock_ok) begin
                        pend_cnt <= 4; pend_kind <= 1;
                    end
                    if (bus_addr == 8'h10 && !bus_wdata[0] && regs[4][0] && lock_ok) begin
                        pend_cnt <= 4; pend_kind <= 1;
                    end
                    if (bus_addr == 8'h10 && bus_wdata[0] && pd_ok) begin
                        pend_cnt <= 4; pend_kind <= 2;
                    end
                end else begin
                    s_rdata <= regs[bus_addr[5:2]];
                end
            end else begin
                s_ack <= 1'b0;
            end
            if (pend_cnt > 0) begin
                pend_cnt <= pend_cnt - 1;
                if (pend_cnt == 1) begin
                    if (pend_kind == 1) regs[1][1] <= 1'b1;
                    else regs[1] <= (regs[1] | 32'h0001_8000) & ~32'h2;
                end
            end
        end
    end

    // R2 monitor: request must hold steady until acknowledged
    always @(posedge clk) begin
        if (!rst && prev_pend) begin
            if (!bus_req || bus_addr != prev_addr || bus_we != prev_we || bus_wdata != prev_wdata)
                stab_bad <= stab_bad + 1;
        end
        prev_pend  <= bus_req && !s_ack && !rst;
        prev_addr  <= bus_addr;
        prev_we    <= bus_we;
        prev_wdata <= bus_wdata;
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
        end
    endtask

    task automatic preset(input logic [31:0] c1, input logic [31:0] c2, input logic [31:0] c3,
                          input logic [31:0] c4, input logic [31:0] st,
                          input logic lk, input logic pd);
        @(negedge clk);
        pre_cfg1 = c1; pre_cfg2 = c2; pre_cfg3 = c3; pre_cfg4 = c4; pre_stat = st;
        lock_ok = lk; pd_ok = pd;
        load_req = 1'b1;
        @(negedge clk);
        load_req = 1'b0;
    endtask

    task automatic pulse_init(input logic sata, input logic [2:0] idx, input logic vld);
        @(negedge clk);
        sata_mode = sata; rate_idx = idx; rate_vld = vld; init_req = 1'b1;
        @(negedge clk);
        init_req = 1'b0;
    endtask

    task automatic pulse_exit(input logic sata);
        @(negedge clk);
        sata_mode = sata; exit_req = 1'b1;
        @(negedge clk);
        exit_req = 1'b0;
    endtask

    // waits for a completion pulse; checks the pulse lasts one cycle (R13)
    task automatic wait_end(output logic d, output logic e, output logic [1:0] code, output int cyc);
        d = 1'b0; e = 1'b0; code = 2'd0; cyc = 0;
        while (!(done || err) && cyc < 4 * TO_CYC) begin
            @(negedge clk);
            cyc++;
        end
        d = done; e = err; code = err_code;
        @(negedge clk);
        chk("R13 pulse width", {30'd0, done, err}, 32'd0);
    endtask

    task automatic t_reset;
        chk("R1 bus_req", {31'd0, bus_req}, 32'd0);
        chk("R1 busy", {31'd0, busy}, 32'd0);
        chk("R1 done/err", {30'd0, done, err}, 32'd0);
        chk("R1 err_code", {30'd0, err_code}, 32'd0);
    endtask

    task automatic t_already_locked;
        logic d, e; logic [1:0] c; int cy;
        preset(32'h1234_5678, 32'h0, 32'h0, 32'h0, 32'h2, 1'b1, 1'b0);
        pulse_init(1'b0, 3'd2, 1'b1);
        wait_end(d, e, c, cy);
        chk("R4 done", {31'd0, d}, 32'd1);
        chk("R4 no writes", wr_n, 0);
        chk("R4 cfg1 untouched", regs[3], 32'h1234_5678);
    endtask

    task automatic t_usb_program;
        logic d, e; logic [1:0] c; int cy;
        logic [31:0] ones = 32'hFFFF_FFFF;
        preset(ones, 32'hA5A5_A5A4, ones, ones, 32'h0, 1'b1, 1'b0);
        pulse_init(1'b0, 3'd2, 1'b1);
        wait_end(d, e, c, cy);
        chk("R6 done", {30'd0, d, e}, 32'd2);
        chk("R5 write count", wr_n, 6);
        chk("R5 order 0", {24'd0, wr_addr[0]}, 32'h0C);
        chk("R5 order 1", {24'd0, wr_addr[1]}, 32'h10);
        chk("R5 order 2", {24'd0, wr_addr[2]}, 32'h0C);
        chk("R5 order 3", {24'd0, wr_addr[3]}, 32'h20);
        chk("R5 order 4", {24'd0, wr_addr[4]}, 32'h14);
        chk("R6 go addr", {24'd0, wr_addr[5]}, 32'h08);
        chk("R6 go data", wr_data[5], 32'h1);
        chk("R12 usb cfg1", regs[3], (ones & ~32'h001F_FFFE) | (32'd8 << 1) | (32'd1172 << 9));
        chk("R12 usb cfg2", regs[4], (32'hA5A5_A5A4 & ~32'hE) | (32'd4 << 1));
        chk("R12 usb cfg4", regs[8], (ones & ~32'h0003_FFFF) | 32'd65537);
        chk("R12 usb cfg3", regs[5], (ones & ~32'h0003_FC00) | (32'd20 << 10));
    endtask

    task automatic t_sata_program;
        logic d, e; logic [1:0] c; int cy;
        preset(32'h0, 32'h0, 32'h0, 32'h0, 32'h0, 1'b1, 1'b0);
        pulse_init(1'b1, 3'd5, 1'b1);
        wait_end(d, e, c, cy);
        chk("R12 sata done", {31'd0, d}, 32'd1);
        chk("R12 sata cfg1", regs[3], (32'd7 << 1) | (32'd312 << 9));
        chk("R12 sata cfg2", regs[4], 32'd4 << 1);
        chk("R12 sata cfg3", regs[5], 32'd6 << 10);
        chk("R12 sata cfg4", regs[8], 32'd0);
    endtask

    task automatic t_unidle;
        logic d, e; logic [1:0] c; int cy;
        preset(32'h0, 32'h0000_0F01, 32'h0, 32'h0, 32'h0, 1'b1, 1'b0);
        pulse_init(1'b0, 3'd0, 1'b1);
        wait_end(d, e, c, cy);
        chk("R3 done", {31'd0, d}, 32'd1);
        chk("R3 single write", wr_n, 1);
        chk("R3 write addr", {24'd0, wr_addr[0]}, 32'h10);
        chk("R3 idle cleared", wr_data[0], 32'h0000_0F00);
    endtask

    task automatic t_bad_rate;
        logic d, e; logic [1:0] c; int cy;
        preset(32'h0, 32'h0, 32'h0, 32'h0, 32'h0, 1'b1, 1'b0);
        pulse_init(1'b0, 3'd6, 1'b1);
        wait_end(d, e, c, cy);
        chk("R8 err idx6", {29'd0, e, c}, {29'd0, 1'b1, 2'd2});
        chk("R8 no writes idx6", wr_n, 0);
        preset(32'h0, 32'h0, 32'h0, 32'h0, 32'h0, 1'b1, 1'b0);
        pulse_init(1'b0, 3'd1, 1'b0);
        wait_end(d, e, c, cy);
        chk("R8 err invalid flag", {29'd0, e, c}, {29'd0, 1'b1, 2'd2});
        chk("R8 no writes invalid flag", wr_n, 0);
    endtask

    task automatic t_lock_timeout;
        logic d, e; logic [1:0] c; int cy;
        preset(32'h0, 32'h0, 32'h0, 32'h0, 32'h0, 1'b0, 1'b0);
        pulse_init(1'b0, 3'd4, 1'b1);
        wait_end(d, e, c, cy);
        chk("R7 err", {29'd0, d, e, 1'b0}, {29'd0, 1'b0, 1'b1, 1'b0});
        chk("R7 code", {30'd0, c}, 32'd1);
        chk("R7 not early", {31'd0, cy >= TO_CYC}, 32'd1);
        chk("R7 programmed first", wr_n, 6);
    endtask

    task automatic t_exit_usb;
        logic d, e; logic [1:0] c; int cy;
        preset(32'h0, 32'h0000_00A0, 32'h0, 32'h0, 32'h2, 1'b0, 1'b1);
        pulse_exit(1'b0);
        wait_end(d, e, c, cy);
        chk("R9 done", {30'd0, d, e}, 32'd2);
        chk("R9 one write", wr_n, 1);
        chk("R9 idle set", wr_data[0], 32'h0000_00A1);
    endtask

    task automatic t_exit_timeout;
        logic d, e; logic [1:0] c; int cy;
        preset(32'h0, 32'h0, 32'h0, 32'h0, 32'h0000_8000, 1'b0, 1'b0);
        pulse_exit(1'b0);
        wait_end(d, e, c, cy);
        chk("R10 err", {30'd0, d, e}, 32'd1);
        chk("R10 code", {30'd0, c}, 32'd1);
    endtask

    task automatic t_exit_sata;
        logic d, e; logic [1:0] c; int cy;
        preset(32'h0, 32'h0, 32'h0, 32'h0, 32'h2, 1'b0, 1'b1);
        pulse_exit(1'b1);
        wait_end(d, e, c, cy);
        chk("R11 done", {30'd0, d, e}, 32'd2);
        chk("R11 no bus access", acc_n, 0);
    endtask

    task automatic t_busy_ignore;
        logic d, e; logic [1:0] c; int cy;
        int extra = 0;
        preset(32'h0, 32'h0, 32'h0, 32'h0, 32'h0, 1'b1, 1'b1);
        pulse_init(1'b0, 3'd3, 1'b1);
        repeat (3) @(negedge clk);
        pulse_exit(1'b0);
        pulse_init(1'b0, 3'd3, 1'b1);
        wait_end(d, e, c, cy);
        chk("R13 first done", {31'd0, d}, 32'd1);
        chk("R13 writes of one init", wr_n, 6);
        chk("R13 no idle write", regs[4][0], 32'd0);
        for (int i = 0; i < 40; i++) begin
            @(negedge clk);
            if (done || err || bus_req) extra++;
        end
        chk("R13 nothing after", extra, 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_already_locked();
        t_usb_program();
        t_sata_program();
        t_unidle();
        t_bad_rate();
        t_lock_timeout();
        t_exit_usb();
        t_exit_timeout();
        t_exit_sata();
        t_busy_ignore();
        chk("R2 request stability", stab_bad, 0);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: actual hung expected finish");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule